// File: doc/BRIEF.md
# Address-Decoding Bus Fabric

This block joins one bus master to a parameterised number of slave ports on a single-clock strobe/ack/err bus. The master's address is compared with a table of per-slave base and mask parameters. The first entry that matches picks the target port. Address, write data and the write bit are fanned out unchanged to every slave. Only the target sees its strobe raised, so each slave decodes just its own local address bits and needs no knowledge of where it sits in the global map.

The return path takes read data, ack and err from the target alone. Responses from every other port are ignored. An address that hits no entry is answered by the fabric itself with err in the same clock as strobe, so the master never waits forever. Adding a slave means raising `N_SLV`, wiring the new port and adding one base and one mask entry.

A small two-state tracker fixes the target for the length of a cycle. In state `FS_IDLE` the target follows the live address decode, which allows zero-wait slaves to respond in the strobe clock. Transition `T_WAIT` (strobe, mapped address, no ack or err from the target) moves the tracker to `FS_HOLD`, where the captured port index is used. Transition `T_DONE` (ack or err from the held target) returns it to `FS_IDLE`. So does transition `T_ABORT` (strobe dropped). Reset forces `FS_IDLE`.

Top module: `addr_fabric`

## Requirements
- R1: At most one bit of `s_strobe` is ever high, and a bit is high only while `m_strobe` is high and the address (or held target) selects that port.
- R2: Port i matches when `(m_addr & SLV_MASK[i]) == (SLV_BASE[i] & SLV_MASK[i])`; address bits where the mask is 0 have no effect on the match.
- R3: When several entries match, the lowest-numbered port is chosen.
- R4: A strobed address that matches no entry raises `m_err` in the same clock, with `m_ack` low and no slave strobe.
- R5: `s_addr`, `s_wdata` and `s_we` equal `m_addr`, `m_wdata` and `m_we` at all times.
- R6: `m_rdata`, `m_ack` and `m_err` come only from the target port; ack and err from other ports are ignored, and `m_rdata` is zero when no port is selected.
- R7: A target that asserts ack or err in the strobe clock completes the cycle in that clock (zero wait states).
- R8: While a cycle is waiting on its target, the strobe stays on that port even if the master address changes, until ack, err or strobe low ends the cycle.
- R9: In the clock after a cycle ends, a strobe with a new address is decoded afresh, so back-to-back cycles to different ports work.
- R10: Active-low reset `rst_n` returns the tracker to the idle state, so the target follows the live decode right after reset.
- R11: With `m_strobe` low, `m_ack` and `m_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_addr | input | AW | Master address |
| m_wdata | input | DW | Master write data |
| m_we | input | 1 | Master write (1) / read (0) |
| m_strobe | input | 1 | Master cycle strobe |
| m_rdata | output | DW | Read data returned to master |
| m_ack | output | 1 | Cycle acknowledge to master |
| m_err | output | 1 | Cycle error to master |
| s_addr | output | AW | Address fanned out to all slaves |
| s_wdata | output | DW | Write data fanned out to all slaves |
| s_we | output | 1 | Write bit fanned out to all slaves |
| s_strobe | output | N_SLV | Per-slave qualified strobe |
| s_rdata | input | N_SLV x DW | Read data from each slave |
| s_ack | input | N_SLV | Acknowledge from each slave |
| s_err | input | N_SLV | Error from each slave |

## Verification
The bench uses overlapping map entries to probe priority. A fabric that scanned from the top index would hand such addresses to the wide catch-all port. It also uses addresses with bits set outside a narrow mask, which a decoder that compared all bits would send to the error path.

Every slave acknowledges at once in the table walk. This exposes a return path that ORs responses instead of selecting one, because such a path would report ack on unmapped addresses. A wait-state cycle with a moving address catches a fabric that retargets mid-cycle, since the strobe would jump ports. The bench also checks aborted cycles and reset during a held cycle, which would leave a stale target in place if the tracker failed to return to idle.

// File: rtl/fab_pkg.sv
package fab_pkg;

    // Cycle tracker states
    typedef enum logic [0:0] {
        FS_IDLE = 1'b0,   // target follows live decode
        FS_HOLD = 1'b1    // target captured, waiting for slave response
    } fab_state_e;

endpackage

// File: rtl/fab_decode.sv
module fab_decode #(
    parameter int N_SLV = 4,
    parameter int AW    = 32,
    parameter int IW    = 2,
    parameter logic [N_SLV-1:0][AW-1:0] SLV_BASE = '0,
    parameter logic [N_SLV-1:0][AW-1:0] SLV_MASK = '0
) (
    input  logic [AW-1:0]    addr,
    output logic [N_SLV-1:0] match_vec,
    output logic [IW-1:0]    first_idx,
    output logic             any_match
);

    // One comparator per map entry; masked-off bits never take part
    for (genvar g = 0; g < N_SLV; g++) begin : g_match
        assign match_vec[g] = ((addr & SLV_MASK[g]) == (SLV_BASE[g] & SLV_MASK[g]));
    end

    // Priority pick: scan downward so the lowest index is written last
    always_comb begin
        first_idx = '0;
        any_match = 1'b0;
        for (int i = N_SLV - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                first_idx = IW'(i);
                any_match = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fab_track.sv
module fab_track
    import fab_pkg::*;
#(
    parameter int N_SLV = 4,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m_strobe,
    input  logic [IW-1:0] dec_idx,
    input  logic          dec_hit,
    input  logic          sel_ack,
    input  logic          sel_err,
    output logic [IW-1:0] use_idx,
    output logic          use_valid
);

    fab_state_e    state, state_nx;
    logic [IW-1:0] held_idx, held_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= FS_IDLE;
            held_idx <= '0;
        end else begin
            state    <= state_nx;
            held_idx <= held_nx;
        end
    end

    // Transitions: T_WAIT, T_DONE, T_ABORT
    always_comb begin
        state_nx = state;
        held_nx  = held_idx;
        unique case (state)
            FS_IDLE: begin
                if (m_strobe && dec_hit && !sel_ack && !sel_err) begin
                    state_nx = FS_HOLD;       // T_WAIT
                    held_nx  = dec_idx;
                end
            end
            FS_HOLD: begin
                if (!m_strobe) begin
                    state_nx = FS_IDLE;       // T_ABORT
                end else if (sel_ack || sel_err) begin
                    state_nx = FS_IDLE;       // T_DONE
                end
            end
        endcase
    end

    // Outputs: which port is targeted this clock
    always_comb begin
        unique case (state)
            FS_IDLE: begin
                use_idx   = dec_idx;
                use_valid = dec_hit;
            end
            FS_HOLD: begin
                use_idx   = held_idx;
                use_valid = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fab_route.sv
module fab_route #(
    parameter int N_SLV = 4,
    parameter int DW    = 32,
    parameter int IW    = 2
) (
    input  logic                      m_strobe,
    input  logic [IW-1:0]             use_idx,
    input  logic                      use_valid,
    input  logic [N_SLV-1:0][DW-1:0]  s_rdata,
    input  logic [N_SLV-1:0]          s_ack,
    input  logic [N_SLV-1:0]          s_err,
    output logic [N_SLV-1:0]          s_strobe,
    output logic [DW-1:0]             m_rdata,
    output logic                      m_ack,
    output logic                      m_err,
    output logic                      sel_ack,
    output logic                      sel_err
);

    // Per-port strobe qualification
    for (genvar g = 0; g < N_SLV; g++) begin : g_stb
        assign s_strobe[g] = m_strobe && use_valid && (use_idx == IW'(g));
    end

    // Return path from the targeted port only
    always_comb begin
        sel_ack = use_valid && s_ack[use_idx];
        sel_err = use_valid && s_err[use_idx];
        m_rdata = use_valid ? s_rdata[use_idx] : '0;
        m_ack   = m_strobe && sel_ack;
        // Unmapped address: fabric answers with err itself
        m_err   = m_strobe && (use_valid ? sel_err : 1'b1);
    end

endmodule

// File: rtl/addr_fabric.sv
module addr_fabric #(
    parameter int N_SLV = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter logic [N_SLV-1:0][AW-1:0] SLV_BASE = {
        32'h0000_0000, 32'h0000_0100, 32'h0000_0010, 32'h0000_0000 },
    parameter logic [N_SLV-1:0][AW-1:0] SLV_MASK = {
        32'hFFFF_0000, 32'h0000_FF00, 32'hFFFF_FFF0, 32'hFFFF_FFF0 }
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [AW-1:0]             m_addr,
    input  logic [DW-1:0]             m_wdata,
    input  logic                      m_we,
    input  logic                      m_strobe,
    output logic [DW-1:0]             m_rdata,
    output logic                      m_ack,
    output logic                      m_err,
    output logic [AW-1:0]             s_addr,
    output logic [DW-1:0]             s_wdata,
    output logic                      s_we,
    output logic [N_SLV-1:0]          s_strobe,
    input  logic [N_SLV-1:0][DW-1:0]  s_rdata,
    input  logic [N_SLV-1:0]          s_ack,
    input  logic [N_SLV-1:0]          s_err
);

    localparam int IW = (N_SLV > 1) ? $clog2(N_SLV) : 1;

    logic [N_SLV-1:0] match_vec;
    logic [IW-1:0]    dec_idx;
    logic             dec_hit;
    logic [IW-1:0]    use_idx;
    logic             use_valid;
    logic             sel_ack;
    logic             sel_err;

    // Shared fan-out to all slaves
    assign s_addr  = m_addr;
    assign s_wdata = m_wdata;
    assign s_we    = m_we;

    fab_decode #(
        .N_SLV    (N_SLV),
        .AW       (AW),
        .IW       (IW),
        .SLV_BASE (SLV_BASE),
        .SLV_MASK (SLV_MASK)
    ) u_decode (
        .addr      (m_addr),
        .match_vec (match_vec),
        .first_idx (dec_idx),
        .any_match (dec_hit)
    );

    fab_track #(
        .N_SLV (N_SLV),
        .IW    (IW)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .m_strobe  (m_strobe),
        .dec_idx   (dec_idx),
        .dec_hit   (dec_hit),
        .sel_ack   (sel_ack),
        .sel_err   (sel_err),
        .use_idx   (use_idx),
        .use_valid (use_valid)
    );

    fab_route #(
        .N_SLV (N_SLV),
        .DW    (DW),
        .IW    (IW)
    ) u_route (
        .m_strobe  (m_strobe),
        .use_idx   (use_idx),
        .use_valid (use_valid),
        .s_rdata   (s_rdata),
        .s_ack     (s_ack),
        .s_err     (s_err),
        .s_strobe  (s_strobe),
        .m_rdata   (m_rdata),
        .m_ack     (m_ack),
        .m_err     (m_err),
        .sel_ack   (sel_ack),
        .sel_err   (sel_err)
    );

    // match_vec is consumed only for its priority result
    logic unused_match;
    assign unused_match = ^match_vec;

endmodule

// File: rtl/fab_fabric_chk.sv
module fab_fabric_chk #(
    parameter int N_SLV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             m_strobe,
    input logic             m_ack,
    input logic             m_err,
    input logic [N_SLV-1:0] s_strobe,
    input logic [N_SLV-1:0] s_ack
);

    // R1
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_strobe));

    // R1
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m_strobe |-> (s_strobe == '0));

    // R4
    unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_strobe && (s_strobe == '0)) |-> (m_err && !m_ack));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m_strobe |-> (!m_ack && !m_err));

    // R6
    ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack |-> ((s_strobe & s_ack) != '0));

    // R8
    hold_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_strobe && !m_ack && !m_err) |=> (!m_strobe || $stable(s_strobe)));

endmodule

bind addr_fabric fab_fabric_chk #(.N_SLV(N_SLV)) u_fabric_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_strobe (m_strobe),
    .m_ack    (m_ack),
    .m_err    (m_err),
    .s_strobe (s_strobe),
    .s_ack    (s_ack)
);

// File: tb/test_addr_fabric.sv
module test_addr_fabric;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int NV = 10;

    // {address, expected one-hot strobe}; strobe 0 means unmapped
    localparam logic [35:0] VEC [NV] = '{
        {32'h0000_0005, 4'b0001},   // R2 slave0
        {32'h0000_000F, 4'b0001},   // R2 slave0 top word
        {32'h0000_0010, 4'b0010},   // R3 slave1 beats slave3
        {32'h0000_001C, 4'b0010},   // R3
        {32'h0000_0020, 4'b1000},   // R2 catch-all slave3
        {32'h0000_01FF, 4'b0100},   // R3 slave2 beats slave3
        {32'hABCD_0105, 4'b0100},   // R2 upper bits ignored for slave2
        {32'h0001_0000, 4'b0000},   // R4 unmapped
        {32'h0000_FFFC, 4'b1000},   // R2 slave3
        {32'hFFFF_FFF0, 4'b0000}    // R4 unmapped
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [31:0]           m_addr = '0;
    logic [31:0]           m_wdata = '0;
    logic                  m_we = 1'b0;
    logic                  m_strobe = 1'b0;
    logic [31:0]           m_rdata;
    logic                  m_ack;
    logic                  m_err;
    logic [31:0]           s_addr;
    logic [31:0]           s_wdata;
    logic                  s_we;
    logic [NS-1:0]         s_strobe;
    logic [NS-1:0][31:0]   s_rdata;
    logic [NS-1:0]         ack_drv = '0;
    logic [NS-1:0]         err_drv = '0;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Each slave returns a fixed word carrying its index
    always_comb begin
        for (int i = 0; i < NS; i++) s_rdata[i] = 32'hC0DE_0000 | 32'(i);
    end

    addr_fabric i_addr_fabric (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_addr   (m_addr),
        .m_wdata  (m_wdata),
        .m_we     (m_we),
        .m_strobe (m_strobe),
        .m_rdata  (m_rdata),
        .m_ack    (m_ack),
        .m_err    (m_err),
        .s_addr   (s_addr),
        .s_wdata  (s_wdata),
        .s_we     (s_we),
        .s_strobe (s_strobe),
        .s_rdata  (s_rdata),
        .s_ack    (ack_drv),
        .s_err    (err_drv)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [31:0] exp_rdata(input logic [NS-1:0] sel);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < NS; i++) if (sel[i]) r = 32'hC0DE_0000 | 32'(i);
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // Reset state
        step();
        step();
        rst_n = 1'b1;
        step();
        #1;
        chk("R1 reset strobe", 64'(s_strobe), 64'(0));
        chk("R11 reset ack", 64'(m_ack), 64'(0));
        chk("R11 reset err", 64'(m_err), 64'(0));

        // Table walk: every slave acks, back-to-back cycles
        for (int v = 0; v < NV; v++) begin
            m_addr   = VEC[v][35:4];
            m_wdata  = 32'h1234_0000 + 32'(v);
            m_we     = v[0];
            m_strobe = 1'b1;
            ack_drv  = '1;
            err_drv  = '0;
            #1;
            chk("R1 R2 R3 strobe", 64'(s_strobe), 64'(VEC[v][3:0]));
            chk("R4 R6 R7 ack", 64'(m_ack), 64'(VEC[v][3:0] != 0));
            chk("R4 err", 64'(m_err), 64'(VEC[v][3:0] == 0));
            chk("R6 rdata", 64'(m_rdata), 64'(exp_rdata(VEC[v][3:0])));
            chk("R5 addr", 64'(s_addr), 64'(m_addr));
            chk("R5 wdata", 64'(s_wdata), 64'(m_wdata));
            chk("R5 we", 64'(s_we), 64'(m_we));
            step();
        end

        // Strobe low with acks present
        m_strobe = 1'b0;
        #1;
        chk("R11 no strobe ack", 64'(m_ack), 64'(0));
        chk("R11 no strobe err", 64'(m_err), 64'(0));
        chk("R1 no strobe", 64'(s_strobe), 64'(0));
        step();

        // Wait-state cycle to slave0
        ack_drv  = '0;
        m_addr   = 32'h0000_0005;
        m_strobe = 1'b1;
        #1;
        chk("R8 wait strobe", 64'(s_strobe), 64'(4'b0001));
        chk("R8 wait ack", 64'(m_ack), 64'(0));
        step();
        // Address moves mid-cycle, others respond
        m_addr  = 32'h0000_0020;
        ack_drv = 4'b1110;
        err_drv = 4'b1110;
        #1;
        chk("R8 held strobe", 64'(s_strobe), 64'(4'b0001));
        chk("R6 foreign ack", 64'(m_ack), 64'(0));
        chk("R6 foreign err", 64'(m_err), 64'(0));
        chk("R6 held rdata", 64'(m_rdata), 64'(32'hC0DE_0000));
        ack_drv = 4'b0001;
        err_drv = '0;
        #1;
        chk("R8 held ack", 64'(m_ack), 64'(1));
        step();
        // Next cycle decodes fresh
        ack_drv = '0;
        #1;
        chk("R9 fresh decode", 64'(s_strobe), 64'(4'b1000));
        step();
        // Abort the held cycle
        m_strobe = 1'b0;
        #1;
        chk("R11 abort quiet", 64'(m_err), 64'(0));
        step();
        m_addr   = 32'h0000_0010;
        m_strobe = 1'b1;
        #1;
        chk("R8 after abort", 64'(s_strobe), 64'(4'b0010));
        // Slave error forwarded
        err_drv = 4'b0010;
        #1;
        chk("R6 slave err", 64'(m_err), 64'(1));
        chk("R6 slave err ack", 64'(m_ack), 64'(0));
        step();

        // Reset during a held cycle
        err_drv = '0;
        m_addr  = 32'h0000_0005;
        step();
        // now held on slave0
        m_addr = 32'h0000_0010;
        #1;
        chk("R8 hold before reset", 64'(s_strobe), 64'(4'b0001));
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        #1;
        chk("R10 reset clears hold", 64'(s_strobe), 64'(4'b0010));
        step();
        m_strobe = 1'b0;
        step();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule